// File: doc/BRIEF.md
# Leaky-Bucket Link Error Rate Monitor

This block scores how clean the receive side of a signalling link is. It keeps a small saturating score that climbs on errored signal units and falls slowly after long runs of good messages. A rising score means link quality is getting worse. The inputs are single-cycle status pulses from an upstream frame receiver. The outputs are the score, a one-cycle pulse for every step up or down, and a flag that shows when the block is counting bad octets.

Errors reach the score by two routes. Discrete frame faults (short frame, octet misalignment, FCS mismatch) add one step each. An abort (seven ones in a row) or an overlong frame puts the block into a bad-octet mode. In that mode every sixteenth received octet adds one step, and the good-message credit is frozen. The mode ends only when a clean message arrives. A separate 8-bit good-message counter takes one step off the score each time it wraps.

Top module: `link_err_monitor`

## Requirements
- R1: A synchronous active-low reset clears the score to 0, clears the mode flag, and drops both event pulses. It also clears the bad-octet and good-message counters.
- R2: In a cycle with a short-frame, alignment or FCS-mismatch pulse, the score rises by exactly one on the next clock edge, together with a one-cycle increment pulse. Several error pulses in the same cycle still give only one step.
- R3: An abort pulse or a long-frame pulse sets the mode flag at the next edge and clears the 4-bit bad-octet counter, even when the block is already in the mode.
- R4: In the mode, each octet pulse advances the bad-octet counter. The octet that takes it from 15 back to 0 raises the score by one. Octet pulses have no effect outside the mode, and none in a cycle that enters the mode.
- R5: The mode flag clears only after a good-message pulse. A discrete error does not clear it. If an abort or long-frame pulse comes in the same cycle as a good message, the block enters or stays in the mode.
- R6: Each good-message pulse advances an 8-bit counter. The pulse that takes it from 255 to 0 lowers the score by one, with a one-cycle decrement pulse.
- R7: The good-message counter keeps its value through the mode. The good message that ends the mode is counted, continuing from that value. A good message that comes in the same cycle as an abort or long-frame pulse is not counted.
- R8: The score saturates. A step up at 63 or a step down at 0 leaves it unchanged, and no pulse is generated. With no step, the score holds.
- R9: A step up and a step down in the same cycle cancel. The score is unchanged and neither pulse fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| short_err_i | input | 1 | Short-frame error pulse |
| align_err_i | input | 1 | Octet alignment error pulse |
| fcs_err_i | input | 1 | FCS mismatch pulse |
| good_msg_i | input | 1 | Unerrored message pulse |
| abort_i | input | 1 | Seven-ones abort pulse |
| long_err_i | input | 1 | Frame over maximum length pulse |
| octet_i | input | 1 | Octet received pulse |
| rate_o | output | 6 | Error-rate score |
| inc_evt_o | output | 1 | Score stepped up |
| dec_evt_o | output | 1 | Score stepped down |
| oct_mode_o | output | 1 | Bad-octet counting mode active |

## Verification
A step up and a step down can fall in the same cycle. The step up comes from a discrete error or the sixteenth bad octet. The step down comes from the good-message wrap. The bench first brings the good-message counter to 255 through a run of clean messages. It then drives an FCS mismatch and the 256th good message in one cycle. The result is judged by checking that the score stays where it was and that neither pulse appears. A second collision places an abort in the same cycle as a good message. The mode must win, and that good message must not be counted, which is checked through the later timing of the decrement.

// File: rtl/lerm_pkg.sv
package lerm_pkg;
   typedef struct packed {
      logic up;
      logic dn;
   } step_req_t;
endpackage

// File: rtl/lerm_octet_tracker.sv
module lerm_octet_tracker #(
   parameter int OCT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic exit_i,
   input  logic octet_i,
   output logic mode_o,
   output logic wrap_o
);
   localparam logic [OCT_W-1:0] OCT_LAST = '1;

   logic             mode_q;
   logic [OCT_W-1:0] cnt_q;
   logic             count_en;

   generate
      if (OCT_W < 1) begin : g_bad_oct_w
         $error("lerm_octet_tracker: OCT_W must be at least 1");
      end
   endgenerate

   assign count_en = mode_q && octet_i && !enter_i;
   assign wrap_o   = count_en && (cnt_q == OCT_LAST);
   assign mode_o   = mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         cnt_q  <= '0;
      end else if (enter_i) begin
         mode_q <= 1'b1;
         cnt_q  <= '0;
      end else begin
         if (exit_i) begin
            mode_q <= 1'b0;
         end
         if (count_en) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lerm_good_counter.sv
module lerm_good_counter #(
   parameter int GOOD_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_i,
   output logic wrap_o
);
   localparam logic [GOOD_W-1:0] GOOD_LAST = '1;

   logic [GOOD_W-1:0] cnt_q;

   generate
      if (GOOD_W < 1) begin : g_bad_good_w
         $error("lerm_good_counter: GOOD_W must be at least 1");
      end
   endgenerate

   assign wrap_o = adv_i && (cnt_q == GOOD_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lerm_rate_counter.sv
module lerm_rate_counter
   import lerm_pkg::*;
#(
   parameter int RATE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  step_req_t         req_i,
   output logic [RATE_W-1:0] rate_o,
   output logic              inc_o,
   output logic              dec_o
);
   localparam logic [RATE_W-1:0] RATE_TOP = '1;

   logic [RATE_W-1:0] rate_q;
   logic              inc_q;
   logic              dec_q;
   logic              go_up;
   logic              go_dn;

   generate
      if (RATE_W < 2) begin : g_bad_rate_w
         $error("lerm_rate_counter: RATE_W must be at least 2");
      end
   endgenerate

   assign go_up = req_i.up && !req_i.dn && (rate_q != RATE_TOP);
   assign go_dn = req_i.dn && !req_i.up && (rate_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= '0;
         inc_q  <= 1'b0;
         dec_q  <= 1'b0;
      end else begin
         inc_q <= go_up;
         dec_q <= go_dn;
         if (go_up) begin
            rate_q <= rate_q + 1'b1;
         end else if (go_dn) begin
            rate_q <= rate_q - 1'b1;
         end
      end
   end

   assign rate_o = rate_q;
   assign inc_o  = inc_q;
   assign dec_o  = dec_q;
endmodule

// File: rtl/link_err_monitor.sv
module link_err_monitor
   import lerm_pkg::*;
#(
   parameter int RATE_W = 6,
   parameter int OCT_W  = 4,
   parameter int GOOD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              short_err_i,
   input  logic              align_err_i,
   input  logic              fcs_err_i,
   input  logic              good_msg_i,
   input  logic              abort_i,
   input  logic              long_err_i,
   input  logic              octet_i,
   output logic [RATE_W-1:0] rate_o,
   output logic              inc_evt_o,
   output logic              dec_evt_o,
   output logic              oct_mode_o
);
   logic      enter_mode;
   logic      oct_wrap;
   logic      good_wrap;
   logic      good_adv;
   step_req_t step_req;

   assign enter_mode = abort_i || long_err_i;
   assign good_adv   = good_msg_i && !enter_mode;

   lerm_octet_tracker #(.OCT_W(OCT_W)) u_oct (
      .clk     (clk),
      .rst_n   (rst_n),
      .enter_i (enter_mode),
      .exit_i  (good_msg_i),
      .octet_i (octet_i),
      .mode_o  (oct_mode_o),
      .wrap_o  (oct_wrap)
   );

   lerm_good_counter #(.GOOD_W(GOOD_W)) u_good (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (good_adv),
      .wrap_o (good_wrap)
   );

   assign step_req.up = short_err_i || align_err_i || fcs_err_i || oct_wrap;
   assign step_req.dn = good_wrap;

   lerm_rate_counter #(.RATE_W(RATE_W)) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (step_req),
      .rate_o (rate_o),
      .inc_o  (inc_evt_o),
      .dec_o  (dec_evt_o)
   );
endmodule

// File: rtl/lerm_checker.sv
module lerm_checker #(
   parameter int RATE_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              good_msg_i,
   input logic              abort_i,
   input logic              long_err_i,
   input logic [RATE_W-1:0] rate_o,
   input logic              inc_evt_o,
   input logic              dec_evt_o,
   input logic              oct_mode_o
);
   // R2: an increment pulse always comes with a one-step rise
   p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      inc_evt_o |-> (rate_o == $past(rate_o) + 1'b1));

   // R6: a decrement pulse always comes with a one-step fall
   p_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_evt_o |-> (rate_o == $past(rate_o) - 1'b1));

   // R8: with no pulse, the score holds
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_evt_o && !dec_evt_o) |-> $stable(rate_o));

   // R9: the two pulses never appear together
   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc_evt_o && dec_evt_o));

   // R3: abort or long frame enters the mode
   p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i || long_err_i) |=> oct_mode_o);

   // R5: without a good message, the mode persists
   p_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (oct_mode_o && !good_msg_i) |=> oct_mode_o);

   // R5: a good message with no entry cause leaves the mode
   p_leave_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (good_msg_i && !abort_i && !long_err_i) |=> !oct_mode_o);
endmodule

bind link_err_monitor lerm_checker #(.RATE_W(RATE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .good_msg_i (good_msg_i),
   .abort_i    (abort_i),
   .long_err_i (long_err_i),
   .rate_o     (rate_o),
   .inc_evt_o  (inc_evt_o),
   .dec_evt_o  (dec_evt_o),
   .oct_mode_o (oct_mode_o)
);

// File: tb/link_err_monitor_tb.sv
`timescale 1ns/1ps
module link_err_monitor_tb;
   typedef struct {
      logic [5:0] rate;
      logic       inc;
      logic       dec;
      logic       mode;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic short_err_i = 0, align_err_i = 0, fcs_err_i = 0, good_msg_i = 0;
   logic abort_i = 0, long_err_i = 0, octet_i = 0;
   logic [5:0] rate_o;
   logic inc_evt_o, dec_evt_o, oct_mode_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   exp_t q[$];

   // reference state, kept from the requirements
   int m_rate = 0, m_oct = 0, m_good = 0;
   bit m_mode = 0;

   always #2.5 clk = ~clk;

   link_err_monitor u_dut (
      .clk(clk), .rst_n(rst_n),
      .short_err_i(short_err_i), .align_err_i(align_err_i), .fcs_err_i(fcs_err_i),
      .good_msg_i(good_msg_i), .abort_i(abort_i), .long_err_i(long_err_i),
      .octet_i(octet_i), .rate_o(rate_o), .inc_evt_o(inc_evt_o),
      .dec_evt_o(dec_evt_o), .oct_mode_o(oct_mode_o)
   );

   task automatic step(input bit sh, input bit al, input bit fc, input bit gd,
                       input bit ab, input bit lg, input bit oc, input string tag);
      bit enter, owrap, up, dn, inc, dec;
      exp_t e;
      @(negedge clk);
      short_err_i = sh; align_err_i = al; fcs_err_i = fc; good_msg_i = gd;
      abort_i = ab; long_err_i = lg; octet_i = oc;
      enter = ab || lg;
      owrap = m_mode && oc && !enter && (m_oct == 15);
      up    = sh || al || fc || owrap;
      dn    = gd && !enter && (m_good == 255);
      inc   = up && !dn && (m_rate < 63);
      dec   = dn && !up && (m_rate > 0);
      if (inc) m_rate++;
      if (dec) m_rate--;
      if (enter) begin
         m_mode = 1; m_oct = 0;
      end else begin
         if (m_mode && oc) m_oct = (m_oct + 1) % 16;
         if (gd) m_mode = 0;
      end
      if (gd && !enter) m_good = (m_good + 1) % 256;
      e.rate = 6'(m_rate); e.inc = inc; e.dec = dec; e.mode = m_mode; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(); step(0,0,0,0,0,0,0,"R8 idle"); endtask

   task automatic goods(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0,0,0,1,0,0,0,tag);
   endtask

   task automatic octets(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0,0,0,0,0,0,1,tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      short_err_i = 0; align_err_i = 0; fcs_err_i = 0; good_msg_i = 0;
      abort_i = 0; long_err_i = 0; octet_i = 0;
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      checks++;
      if (rate_o !== 6'd0 || inc_evt_o !== 1'b0 || dec_evt_o !== 1'b0 || oct_mode_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: rate=%0d inc=%b dec=%b mode=%b expected rate=0 inc=0 dec=0 mode=0",
                  rate_o, inc_evt_o, dec_evt_o, oct_mode_o);
      end
      m_rate = 0; m_oct = 0; m_good = 0; m_mode = 0;
      rst_n = 1;
   endtask

   // monitor: compares each registered result one edge after its stimulus
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rate_o !== e.rate || inc_evt_o !== e.inc || dec_evt_o !== e.dec ||
                oct_mode_o !== e.mode) begin
               errors++;
               $display("FAIL %s: rate=%0d inc=%b dec=%b mode=%b expected rate=%0d inc=%b dec=%b mode=%b",
                        e.tag, rate_o, inc_evt_o, dec_evt_o, oct_mode_o,
                        e.rate, e.inc, e.dec, e.mode);
            end
         end
      end
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();                                   // R1
      step(1,0,0,0,0,0,0,"R2 short");
      step(0,1,0,0,0,0,0,"R2 align");
      step(0,0,1,0,0,0,0,"R2 fcs");
      step(1,1,1,0,0,0,0,"R2 all three one step");
      idle();
      octets(5, "R4 octets outside mode ignored");
      step(0,0,0,0,1,0,1,"R3 abort enters, octet ignored");
      octets(15, "R4 fifteen octets no step");
      octets(1, "R4 sixteenth octet steps up");
      octets(10, "R4 partial run");
      step(0,0,0,0,0,1,0,"R3 long frame re-entry clears count");
      octets(15, "R3 cleared count no step");
      octets(1, "R3 wrap after clear");
      step(0,0,1,0,0,0,0,"R5 error keeps mode");
      step(0,0,0,1,1,0,0,"R5 entry beats good message");
      step(0,0,0,1,0,0,0,"R5 good exits mode");
      goods(199, "R6 good run");
      step(0,0,0,0,1,0,0,"R7 enter mode mid count");
      octets(40, "R7 octets in mode");
      goods(55, "R7 count resumes from held value");
      goods(1, "R6 wrap steps down");
      goods(255, "R9 prime good counter");
      step(0,0,1,1,0,0,0,"R9 up and down cancel");
      for (int i = 0; i < 70; i++) step(0,0,1,0,0,0,0,"R8 saturate at top");
      idle();
      step(0,0,0,0,1,0,0,"R1 mode before reset");
      do_reset();                                   // R1 clears mode and counters
      goods(256, "R8 floor no step at zero");
      step(1,0,0,0,0,0,0,"R2 after floor");
      idle();
      idle();
      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule